// File: doc/BRIEF.md
# Split-Row Threshold Check-Node Processor

This block is the check-node update of a min-sum LDPC decoder for one parity-check row. The row is split into partitions, and each partition sees only its own slice of the row's variable-to-check messages. Every partition finds the smallest and second-smallest magnitude in its slice, along with the position of the smallest. The partitions do not send these minima to each other. Each partition sends only a one-bit flag that says its local minimum is below a threshold, and one bit of sign parity.

A partition that sees a flag from any other partition limits its returned magnitudes to the threshold. It does this because a small value exists somewhere else in the row, even though the partition does not know that value. Both flag and parity travel along a combinational chain through the partitions, so the whole row settles within one update.

Messages are sign-magnitude values. A row is loaded on a valid strobe, and the corrected check-to-variable messages appear one clock later with a matching valid. The threshold is held in a register. It resets to the quantized value of 0.2 and can be rewritten between rows.

Top module: `srt_cnu`

## Requirements
- R1: During and immediately after reset, `out_valid` is 0 and the threshold register holds `THR_RESET` (default 3).
- R2: `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is low, `out_msg` holds the result of the last accepted row.
- R3: Bit p of `part_flag` is 1 exactly when the smallest input magnitude among edges p*K to p*K+K-1 (K = ROW_W/NPART) is strictly less than the threshold. A minimum equal to the threshold gives 0.
- R4: When no other partition's flag is set, the magnitude for an edge is the minimum of the other input magnitudes in its own partition.
- R5: When any other partition's flag is set, the magnitude for an edge is the smaller of the R4 value and the threshold.
- R6: The edge holding a partition's unique smallest magnitude receives the partition's second-smallest. When the smallest value is tied, every edge in the partition receives that value.
- R7: The output sign bit (bit MAG_W of each message, 1 = negative) is the XOR of the sign bits of all other edges in the whole row.
- R8: A write of `thr_wdata` with `thr_wr` high replaces the threshold. The new value applies to every row accepted on a later clock edge. The value 0 keeps every flag low.
- R9: Edge e occupies `in_msg[e*MSG_W +: MSG_W]` and `out_msg[e*MSG_W +: MSG_W]`, where MSG_W = MAG_W+1. The magnitude is in the low MAG_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accepts `in_msg` on this edge |
| in_msg | input | ROW_W*(MAG_W+1) | Variable-to-check messages for the row |
| thr_wr | input | 1 | Threshold write strobe |
| thr_wdata | input | MAG_W | New threshold magnitude |
| out_valid | output | 1 | `out_msg` holds a fresh result |
| out_msg | output | ROW_W*(MAG_W+1) | Check-to-variable messages |
| part_flag | output | NPART | Below-threshold flag of each partition |

## Verification
The hardest condition to reach from the ports is a partition whose own minimum is tied or sits exactly at the threshold while another partition's flag clips it. Under uniform random magnitudes, the minima of all partitions usually fall below the threshold together, so the unclipped path and the strict-compare boundary are rarely exercised.

The stimulus therefore includes hand-built rows:
- one partition alone below the threshold;
- a partition at exactly the threshold;
- ties at the minimum;
- two flagging partitions.

Random rows follow, drawn from a biased magnitude range. The threshold is rewritten to 0 and to full scale so that the flags switch entirely off and then fire on almost every row.

// File: rtl/srt_pkg.sv
package srt_pkg;
   localparam int unsigned SRT_MAX_MAG_W = 8;

   function automatic bit srt_legal_split(input int unsigned n);
      return (n == 2) || (n == 4) || (n == 8) || (n == 16);
   endfunction
endpackage

// File: rtl/srt_minfind.sv
module srt_minfind #(
   parameter int unsigned K     = 4,
   parameter int unsigned MAG_W = 4,
   localparam int unsigned IDX_W = (K > 1) ? $clog2(K) : 1
) (
   input  logic [K*MAG_W-1:0] mags,
   output logic [MAG_W-1:0]   m1,
   output logic [MAG_W-1:0]   m2,
   output logic [IDX_W-1:0]   m1_idx
);
   always_comb begin
      m1     = '1;
      m2     = '1;
      m1_idx = '0;
      for (int i = 0; i < int'(K); i++) begin
         if (mags[i*MAG_W +: MAG_W] < m1) begin
            m2     = m1;
            m1     = mags[i*MAG_W +: MAG_W];
            m1_idx = IDX_W'(i);
         end else if (mags[i*MAG_W +: MAG_W] < m2) begin
            m2 = mags[i*MAG_W +: MAG_W];
         end
      end
   end
endmodule

// File: rtl/srt_flag_chain.sv
module srt_flag_chain #(
   parameter int unsigned NPART = 8
) (
   input  logic [NPART-1:0] loc_flag,
   input  logic [NPART-1:0] loc_par,
   output logic [NPART-1:0] oth_flag,
   output logic [NPART-1:0] oth_par
);
   logic [NPART-1:0] fwd_f, bwd_f, fwd_p, bwd_p;

   assign fwd_f[0]       = loc_flag[0];
   assign fwd_p[0]       = loc_par[0];
   assign bwd_f[NPART-1] = loc_flag[NPART-1];
   assign bwd_p[NPART-1] = loc_par[NPART-1];

   for (genvar i = 1; i < NPART; i++) begin : g_fwd
      assign fwd_f[i] = fwd_f[i-1] | loc_flag[i];
      assign fwd_p[i] = fwd_p[i-1] ^ loc_par[i];
   end

   for (genvar i = NPART - 1; i > 0; i--) begin : g_bwd
      assign bwd_f[i-1] = bwd_f[i] | loc_flag[i-1];
      assign bwd_p[i-1] = bwd_p[i] ^ loc_par[i-1];
   end

   for (genvar p = 0; p < NPART; p++) begin : g_tap
      if (p == 0) begin : g_first
         assign oth_flag[p] = bwd_f[p+1];
         assign oth_par[p]  = bwd_p[p+1];
      end else if (p == NPART - 1) begin : g_last
         assign oth_flag[p] = fwd_f[p-1];
         assign oth_par[p]  = fwd_p[p-1];
      end else begin : g_mid
         assign oth_flag[p] = fwd_f[p-1] | bwd_f[p+1];
         assign oth_par[p]  = fwd_p[p-1] ^ bwd_p[p+1];
      end
   end
endmodule

// File: rtl/srt_partition.sv
module srt_partition #(
   parameter int unsigned K     = 4,
   parameter int unsigned MAG_W = 4,
   localparam int unsigned MSG_W = MAG_W + 1,
   localparam int unsigned IDX_W = (K > 1) ? $clog2(K) : 1
) (
   input  logic [K*MSG_W-1:0] in_msg,
   input  logic [MAG_W-1:0]   thr,
   input  logic               oth_flag,
   input  logic               oth_par,
   output logic               loc_flag,
   output logic               loc_par,
   output logic [K*MSG_W-1:0] out_msg
);
   logic [K*MAG_W-1:0] mags;
   logic [K-1:0]       sgns;
   logic [MAG_W-1:0]   m1, m2, m1c, m2c;
   logic [IDX_W-1:0]   m1_idx;
   logic               row_par;

   for (genvar i = 0; i < K; i++) begin : g_split
      assign mags[i*MAG_W +: MAG_W] = in_msg[i*MSG_W +: MAG_W];
      assign sgns[i]                = in_msg[i*MSG_W + MAG_W];
   end

   srt_minfind #(.K(K), .MAG_W(MAG_W)) u_min (
      .mags   (mags),
      .m1     (m1),
      .m2     (m2),
      .m1_idx (m1_idx)
   );

   assign loc_flag = (m1 < thr);
   assign loc_par  = ^sgns;
   assign row_par  = loc_par ^ oth_par;

   assign m1c = (oth_flag && (thr < m1)) ? thr : m1;
   assign m2c = (oth_flag && (thr < m2)) ? thr : m2;

   for (genvar i = 0; i < K; i++) begin : g_out
      assign out_msg[i*MSG_W + MAG_W]   = row_par ^ sgns[i];
      assign out_msg[i*MSG_W +: MAG_W]  = (m1_idx == IDX_W'(i)) ? m2c : m1c;
   end
endmodule

// File: rtl/srt_cnu.sv
module srt_cnu #(
   parameter int unsigned NPART     = 8,
   parameter int unsigned ROW_W     = 32,
   parameter int unsigned MAG_W     = 4,
   parameter int unsigned THR_RESET = 3,
   localparam int unsigned MSG_W = MAG_W + 1,
   localparam int unsigned K     = ROW_W / NPART,
   localparam int unsigned PW    = K * MSG_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [ROW_W*MSG_W-1:0] in_msg,
   input  logic                   thr_wr,
   input  logic [MAG_W-1:0]       thr_wdata,
   output logic                   out_valid,
   output logic [ROW_W*MSG_W-1:0] out_msg,
   output logic [NPART-1:0]       part_flag
);
   import srt_pkg::*;

   if (!srt_legal_split(NPART)) begin : g_bad_split
      $error("srt_cnu: NPART must be 2, 4, 8 or 16");
   end
   if ((ROW_W % NPART) != 0 || K < 2) begin : g_bad_row
      $error("srt_cnu: ROW_W must be a multiple of NPART with at least 2 edges each");
   end
   if (MAG_W < 2 || MAG_W > SRT_MAX_MAG_W) begin : g_bad_mag
      $error("srt_cnu: MAG_W out of range");
   end

   logic [ROW_W*MSG_W-1:0] msg_q;
   logic [MAG_W-1:0]       thr_q;
   logic [MAG_W-1:0]       thr_cap;
   logic                   vld_q;
   logic [NPART-1:0]       loc_flag, loc_par, oth_flag, oth_par;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_q   <= '0;
         thr_q   <= MAG_W'(THR_RESET);
         thr_cap <= MAG_W'(THR_RESET);
         vld_q   <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            msg_q   <= in_msg;
            thr_cap <= thr_q;
         end
         if (thr_wr) begin
            thr_q <= thr_wdata;
         end
      end
   end

   srt_flag_chain #(.NPART(NPART)) u_chain (
      .loc_flag (loc_flag),
      .loc_par  (loc_par),
      .oth_flag (oth_flag),
      .oth_par  (oth_par)
   );

   for (genvar p = 0; p < NPART; p++) begin : g_part
      srt_partition #(.K(K), .MAG_W(MAG_W)) u_part (
         .in_msg   (msg_q[p*PW +: PW]),
         .thr      (thr_cap),
         .oth_flag (oth_flag[p]),
         .oth_par  (oth_par[p]),
         .loc_flag (loc_flag[p]),
         .loc_par  (loc_par[p]),
         .out_msg  (out_msg[p*PW +: PW])
      );
   end

   assign out_valid = vld_q;
   assign part_flag = loc_flag;
endmodule

// File: rtl/srt_cnu_chk.sv
module srt_cnu_chk #(
   parameter int unsigned NPART = 8,
   parameter int unsigned ROW_W = 32,
   parameter int unsigned MAG_W = 4,
   localparam int unsigned MSG_W = MAG_W + 1,
   localparam int unsigned K     = ROW_W / NPART
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   in_valid,
   input logic                   out_valid,
   input logic [ROW_W*MSG_W-1:0] out_msg,
   input logic [NPART-1:0]       part_flag,
   input logic [MAG_W-1:0]       thr_cap
);
   logic [NPART-1:0][K-1:0] below;
   logic [NPART-1:0][K-1:0] at_most;
   logic [NPART-1:0]        others;

   always_comb begin
      for (int p = 0; p < int'(NPART); p++) begin
         others[p] = |(part_flag & ~(NPART'(1) << p));
         for (int i = 0; i < int'(K); i++) begin
            below[p][i]   = out_msg[(p*K+i)*MSG_W +: MAG_W] <  thr_cap;
            at_most[p][i] = out_msg[(p*K+i)*MSG_W +: MAG_W] <= thr_cap;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_idle_in_reset: assert (!out_valid);
      end
   end

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && out_valid) |=> $stable(out_msg));

   for (genvar p = 0; p < NPART; p++) begin : g_p
      a_r3_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && part_flag[p]) |-> ($countones(below[p]) >= (K - 1)));
      a_r5_clip: assert property (@(posedge clk) disable iff (!rst_n)
         (out_valid && others[p]) |-> (&at_most[p]));
   end
endmodule

bind srt_cnu srt_cnu_chk #(.NPART(NPART), .ROW_W(ROW_W), .MAG_W(MAG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_msg   (out_msg),
   .part_flag (part_flag),
   .thr_cap   (thr_cap)
);

// File: tb/srt_cnu_tb.sv
module srt_cnu_tb;
   localparam int NPART = 8;
   localparam int ROW_W = 32;
   localparam int MAG_W = 4;
   localparam int MSG_W = MAG_W + 1;
   localparam int K     = ROW_W / NPART;
   localparam int MAXM  = (1 << MAG_W) - 1;

   logic                   clk = 0;
   logic                   rst_n = 0;
   logic                   in_valid = 0;
   logic [ROW_W*MSG_W-1:0] in_msg = '0;
   logic                   thr_wr = 0;
   logic [MAG_W-1:0]       thr_wdata = '0;
   logic                   out_valid;
   logic [ROW_W*MSG_W-1:0] out_msg;
   logic [NPART-1:0]       part_flag;

   int errors = 0;
   int checks = 0;
   int thr_m  = 3;
   int mag [ROW_W];
   int sgn [ROW_W];
   logic [ROW_W*MSG_W-1:0] last_out;

   always #2 clk = ~clk;

   srt_cnu u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_msg(in_msg),
      .thr_wr(thr_wr), .thr_wdata(thr_wdata), .out_valid(out_valid),
      .out_msg(out_msg), .part_flag(part_flag)
   );

   task automatic tally(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic fill(input int m, input int s);
      for (int e = 0; e < ROW_W; e++) begin
         mag[e] = m;
         sgn[e] = s;
      end
   endtask

   task automatic send_and_check(input string req);
      int pmin [NPART];
      int exp_flags;
      int bad_e;
      int exp_m, exp_s, act_m, act_s;
      for (int e = 0; e < ROW_W; e++) begin
         in_msg[e*MSG_W +: MSG_W] = {sgn[e][0], MAG_W'(mag[e])};
      end
      in_valid = 1;
      @(negedge clk);
      in_valid = 0;
      exp_flags = 0;
      for (int p = 0; p < NPART; p++) begin
         pmin[p] = MAXM + 1;
         for (int i = 0; i < K; i++) if (mag[p*K+i] < pmin[p]) pmin[p] = mag[p*K+i];
         if (pmin[p] < thr_m) exp_flags |= (1 << p);
      end
      tally(out_valid === 1'b1, "R2", "out_valid after accept", out_valid, 1);
      tally(part_flag === NPART'(exp_flags), {"R3 ", req}, "part_flag",
            part_flag, exp_flags);
      bad_e = -1;
      exp_m = 0; exp_s = 0; act_m = 0; act_s = 0;
      for (int e = 0; e < ROW_W; e++) begin
         int p, m, s, am, as;
         bit oth;
         p = e / K;
         m = MAXM;
         for (int i = 0; i < K; i++) if ((p*K+i) != e && mag[p*K+i] < m) m = mag[p*K+i];
         oth = 0;
         for (int q = 0; q < NPART; q++) if (q != p && pmin[q] < thr_m) oth = 1;
         if (oth && thr_m < m) m = thr_m;
         s = 0;
         for (int j = 0; j < ROW_W; j++) if (j != e) s ^= sgn[j];
         am = int'(out_msg[e*MSG_W +: MAG_W]);
         as = int'(out_msg[e*MSG_W + MAG_W]);
         if (bad_e < 0 && (am != m || as != s)) begin
            bad_e = e; exp_m = m; exp_s = s; act_m = am; act_s = as;
         end
      end
      tally(bad_e < 0, req, $sformatf("edge %0d {sign,mag}", bad_e),
            (act_s << 8) | act_m, (exp_s << 8) | exp_m);
      last_out = out_msg;
   endtask

   task automatic write_thr(input int v);
      thr_wdata = MAG_W'(v);
      thr_wr = 1;
      @(negedge clk);
      thr_wr = 0;
      thr_m = v;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      tally(out_valid === 1'b0, "R1", "out_valid in reset", out_valid, 0);
      rst_n = 1;
      @(negedge clk);
      tally(out_valid === 1'b0, "R1", "out_valid after reset", out_valid, 0);

      // R4 / R1: all large, positive; reset threshold 3 gives no flags
      fill(MAXM, 0);
      send_and_check("R4 all-max");

      // R2: idle cycle drops valid, output held
      @(negedge clk);
      tally(out_valid === 1'b0, "R2", "out_valid idle", out_valid, 0);
      tally(out_msg === last_out, "R2", "out_msg held", out_msg[31:0], last_out[31:0]);

      // R5 / R6: partition 1 alone below threshold, others clipped
      fill(9, 0);
      mag[5] = 1; mag[6] = 7; sgn[2] = 1; sgn[20] = 1; sgn[31] = 1;
      send_and_check("R5 R6 R7 single-flag");

      // R3 boundary: minimum equal to threshold is not flagged
      fill(12, 0);
      mag[9] = 3; mag[17] = 5;
      send_and_check("R3 equal-threshold");

      // R6 tie at the minimum, R5 with two flagging partitions
      fill(10, 1);
      mag[0] = 2; mag[1] = 2; mag[28] = 0; mag[29] = 6;
      send_and_check("R6 R5 tie-two-flags");

      // R7 odd sign count
      fill(8, 0);
      sgn[3] = 1; sgn[4] = 1; sgn[11] = 1; mag[13] = 2;
      send_and_check("R7 sign-parity");

      // R8: threshold 0 disables flags
      write_thr(0);
      fill(6, 0);
      mag[0] = 0; mag[12] = 1;
      send_and_check("R8 thr-zero");

      // R8: full-scale threshold flags nearly everything
      write_thr(MAXM);
      fill(13, 0);
      mag[7] = 14; mag[22] = 4;
      send_and_check("R8 thr-max");

      write_thr(3);
      for (int n = 0; n < 300; n++) begin
         for (int e = 0; e < ROW_W; e++) begin
            mag[e] = (n % 3 == 0) ? int'($urandom_range(MAXM)) : int'($urandom_range(MAXM, 2));
            sgn[e] = int'($urandom_range(1));
         end
         send_and_check("R4 R5 R6 R7 R9 random");
         if (n % 50 == 25) write_thr(int'($urandom_range(MAXM)));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule